// File: doc/BRIEF.md
# Clock-Hand Second-Chance Victim Selector

This block picks which of a fixed set of frame slots gets the next incoming page. The slots form a ring, and a hand pointer marks the oldest load. Each slot carries one "recently used" flag. External access events set a slot's flag. A periodic aging strobe clears every flag at once.

When a victim is requested, the engine looks at one slot per clock, at the hand. A slot whose flag is set gets a second chance: its flag is cleared and the hand moves on. The first slot found with a clear flag becomes the victim. The engine reports that slot with a one-cycle done pulse. The new page is then treated as loaded there, so its flag is set and the hand moves past it.

If no slot has a clear flag, one full lap clears them all and the slot where the search began is chosen. This gives the same result as first-in first-out, only later. A requester waits for done before it asks again, and busy shows when a request would be ignored.

Top module: `clock_evict_engine`

## Requirements
- R1: After reset, busy_o and done_o are low, the hand is at slot 0 and all flags are clear, so the first request returns slot 0 after a single inspection.
- R2: During a search, a slot under the hand whose flag is set is not chosen. On that edge its flag is cleared and the hand advances by one.
- R3: During a search, a slot under the hand whose flag is clear is chosen. On that edge done_o rises for exactly one cycle, victim_o shows the slot and busy_o falls. The first inspection happens on the edge after the one that accepts the request, and latency counts inspections.
- R4: When every flag is set at the start of a search, the search takes N_SLOTS+1 inspections and returns the slot where it began.
- R5: age_clr_i clears all flags on the next edge. Two things still win over it on that same edge: an access, which still sets its slot, and the hand's victim load.
- R6: After choosing a victim, the hand moves to the next slot in ring order (slot N_SLOTS-1 wraps to 0) and the victim's flag is set. The hand moves only during a search, one slot per edge.
- R7: An access (acc_valid_i with slot acc_slot_i) sets that slot's flag whether the engine is idle or searching. The inspection decision uses the flag value from before the edge. If an access hits the slot under the hand on an inspection edge, the hand's action wins.
- R8: busy_o is high from the edge that accepts a request until the edge that produces done_o. A request made while busy_o is high is ignored and produces no extra done_o.
- R9: With no accesses and no aging, back-to-back requests return slots in increasing ring order, starting at the hand, each after one inspection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a victim (accepted only when idle) |
| acc_valid_i | input | 1 | Access event strobe |
| acc_slot_i | input | IDX_W | Slot touched by the access event |
| age_clr_i | input | 1 | Clear all used flags |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse: victim_o is valid |
| victim_o | output | IDX_W | Chosen slot |

## Verification
The bench targets four corner cases.

- **Full lap with every flag set.** A selector that stopped after N_SLOTS inspections, or returned the slot after the start, would show the wrong latency or the wrong slot.
- **Access colliding with the hand.** If the access won that collision, the skipped slot would keep its flag, and a later search would wrap past it with a visibly longer latency.
- **Access just ahead of the hand during a search.** This must turn a would-be victim into a skip.
- **Request made while busy.** A selector that accepted it would emit a second done pulse.

A pseudo-random phase then runs accesses, aging and requests against a cycle model written from the requirements. That model also exposes wrong priority between aging, access and the hand.

// File: rtl/clk_evict_pkg.sv
package clk_evict_pkg;
   typedef enum logic [0:0] {
      SCAN_IDLE = 1'b0,
      SCAN_RUN  = 1'b1
   } scan_state_e;
endpackage

// File: rtl/evict_flag_bank.sv
module evict_flag_bank #(
   parameter int N_SLOTS = 8,
   parameter int IDX_W   = $clog2(N_SLOTS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               age_clr,
   input  logic               acc_valid,
   input  logic [IDX_W-1:0]   acc_slot,
   input  logic               hand_en,
   input  logic               hand_load,
   input  logic [IDX_W-1:0]   hand_slot,
   output logic [N_SLOTS-1:0] flags
);
   // per-slot flag with priority: hand action, then access, then aging
   for (genvar gi = 0; gi < N_SLOTS; gi++) begin : g_slot
      logic flag_q;
      logic at_hand;
      logic touched;
      assign at_hand = hand_en && (hand_slot == IDX_W'(gi));
      assign touched = acc_valid && (acc_slot == IDX_W'(gi));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (at_hand) begin
            flag_q <= hand_load;
         end else if (touched) begin
            flag_q <= 1'b1;
         end else if (age_clr) begin
            flag_q <= 1'b0;
         end
      end
      assign flags[gi] = flag_q;
   end
endmodule

// File: rtl/evict_hand.sv
module evict_hand #(
   parameter int N_SLOTS = 8,
   parameter int IDX_W   = $clog2(N_SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [IDX_W-1:0] hand
);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_SLOTS - 1);
   localparam bit POW2 = ((1 << IDX_W) == N_SLOTS);

   logic [IDX_W-1:0] hand_q;
   logic [IDX_W-1:0] hand_nx;

   if (POW2) begin : g_wrap_free
      assign hand_nx = hand_q + 1'b1;
   end else begin : g_wrap_cmp
      assign hand_nx = (hand_q == LAST_SLOT) ? '0 : hand_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hand_q <= '0;
      end else if (step) begin
         hand_q <= hand_nx;
      end
   end

   assign hand = hand_q;
endmodule

// File: rtl/evict_ctrl.sv
module evict_ctrl
   import clk_evict_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             flag_at_hand,
   input  logic [IDX_W-1:0] hand,
   output logic             busy,
   output logic             step,
   output logic             hand_load,
   output logic             done,
   output logic [IDX_W-1:0] victim
);
   scan_state_e state_q;
   logic        hit;

   assign busy      = (state_q == SCAN_RUN);
   assign step      = busy;
   assign hit       = busy && !flag_at_hand;
   assign hand_load = !flag_at_hand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SCAN_IDLE;
         done    <= 1'b0;
         victim  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            SCAN_IDLE: if (req) state_q <= SCAN_RUN;
            SCAN_RUN: begin
               if (hit) begin
                  done    <= 1'b1;
                  victim  <= hand;
                  state_q <= SCAN_IDLE;
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/clock_evict_engine.sv
module clock_evict_engine #(
   parameter int N_SLOTS = 8,
   parameter int IDX_W   = $clog2(N_SLOTS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic             acc_valid_i,
   input  logic [IDX_W-1:0] acc_slot_i,
   input  logic             age_clr_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [IDX_W-1:0] victim_o
);
   if (N_SLOTS < 2) begin : g_bad_slots
      $error("clock_evict_engine: N_SLOTS must be at least 2");
   end
   if ((1 << IDX_W) < N_SLOTS) begin : g_bad_width
      $error("clock_evict_engine: IDX_W too narrow for N_SLOTS");
   end

   logic [N_SLOTS-1:0] flags_q;
   logic [IDX_W-1:0]   hand_q;
   logic               step;
   logic               hand_load;
   logic               flag_at_hand;

   assign flag_at_hand = flags_q[hand_q];

   evict_flag_bank #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .age_clr   (age_clr_i),
      .acc_valid (acc_valid_i),
      .acc_slot  (acc_slot_i),
      .hand_en   (step),
      .hand_load (hand_load),
      .hand_slot (hand_q),
      .flags     (flags_q)
   );

   evict_hand #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_hand (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .hand  (hand_q)
   );

   evict_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req_i),
      .flag_at_hand (flag_at_hand),
      .hand         (hand_q),
      .busy         (busy_o),
      .step         (step),
      .hand_load    (hand_load),
      .done         (done_o),
      .victim       (victim_o)
   );
endmodule

// File: rtl/clock_evict_engine_chk.sv
module clock_evict_engine_chk #(
   parameter int N_SLOTS = 8,
   parameter int IDX_W   = $clog2(N_SLOTS)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_i,
   input logic               acc_valid_i,
   input logic [IDX_W-1:0]   acc_slot_i,
   input logic               age_clr_i,
   input logic               busy_o,
   input logic               done_o,
   input logic [IDX_W-1:0]   victim_o,
   input logic [IDX_W-1:0]   hand,
   input logic [N_SLOTS-1:0] flags
);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_SLOTS - 1);

   // R2: a set flag under the hand is cleared and skipped
   p_skip_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && flags[hand]) |=> (!flags[$past(hand)] && !done_o));

   // R3: a clear flag under the hand yields a victim
   p_victim_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !flags[hand]) |=> (done_o && !busy_o && victim_o == $past(hand)));

   p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R5: aging with no access and no search empties the flags
   p_age_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age_clr_i && !acc_valid_i && !busy_o) |=> (flags == '0));

   // R6: hand steps by one in ring order while searching, holds otherwise
   p_hand_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (hand == (($past(hand) == LAST_SLOT) ? '0 : $past(hand) + 1'b1)));

   p_hand_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |=> $stable(hand));

   p_victim_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> flags[victim_o]);

   // R7: an access away from the hand's slot sets the flag
   p_access_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !(busy_o && acc_slot_i == hand)) |=> flags[$past(acc_slot_i)]);

   // R8: idle request starts a search; done only ends one
   p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && req_i) |=> busy_o);

   p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(busy_o));
endmodule

bind clock_evict_engine clock_evict_engine_chk #(
   .N_SLOTS(N_SLOTS),
   .IDX_W  (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_i       (req_i),
   .acc_valid_i (acc_valid_i),
   .acc_slot_i  (acc_slot_i),
   .age_clr_i   (age_clr_i),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .victim_o    (victim_o),
   .hand        (hand_q),
   .flags       (flags_q)
);

// File: tb/clock_evict_engine_test.sv
module clock_evict_engine_test;
   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_i = 1'b0;
   logic          acc_valid_i = 1'b0;
   logic [IW-1:0] acc_slot_i = '0;
   logic          age_clr_i = 1'b0;
   logic          busy_o;
   logic          done_o;
   logic [IW-1:0] victim_o;

   int checks = 0;
   int failures = 0;
   int dones_seen = 0;
   bit ended = 1'b0;

   always #5 clk = ~clk;

   clock_evict_engine #(.N_SLOTS(N), .IDX_W(IW)) uut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_valid_i(acc_valid_i),
      .acc_slot_i(acc_slot_i), .age_clr_i(age_clr_i),
      .busy_o(busy_o), .done_o(done_o), .victim_o(victim_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // cycle model written from the requirements
   logic [N-1:0]  m_ref;
   logic [IW-1:0] m_hand;
   logic          m_busy, m_done;
   logic [IW-1:0] m_vic;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ref <= '0; m_hand <= '0; m_busy <= 1'b0; m_done <= 1'b0; m_vic <= '0;
      end else begin
         logic [N-1:0] nref;
         nref = age_clr_i ? '0 : m_ref;
         if (acc_valid_i) nref[acc_slot_i] = 1'b1;
         m_done <= 1'b0;
         if (m_busy) begin
            if (m_ref[m_hand]) begin
               nref[m_hand] = 1'b0;
            end else begin
               nref[m_hand] = 1'b1;
               m_done <= 1'b1;
               m_vic  <= m_hand;
               m_busy <= 1'b0;
            end
            m_hand <= m_hand + 1'b1;
         end else if (req_i) begin
            m_busy <= 1'b1;
         end
         m_ref <= nref;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !ended) begin
         check(busy_o == m_busy, "R8 busy vs model", busy_o, m_busy);
         if (done_o || m_done) begin
            check(done_o == m_done, "R3 done vs model", done_o, m_done);
            check(victim_o == m_vic, "R3 victim vs model", victim_o, m_vic);
         end
         if (done_o) dones_seen++;
      end
   end

   task automatic touch(input int s);
      @(negedge clk); acc_valid_i = 1'b1; acc_slot_i = IW'(s);
      @(negedge clk); acc_valid_i = 1'b0;
   endtask

   task automatic age();
      @(negedge clk); age_clr_i = 1'b1;
      @(negedge clk); age_clr_i = 1'b0;
   endtask

   // request; optional access in the cycle landing on the first inspection edge;
   // optional duplicate request while busy
   task automatic ask(input int exp_vic, input int exp_lat, input string tag,
                      input bit acc_en = 0, input int acc_s = 0, input bit dup = 0);
      int lat;
      @(negedge clk); req_i = 1'b1;
      @(negedge clk); req_i = 1'b0;
      if (acc_en) begin acc_valid_i = 1'b1; acc_slot_i = IW'(acc_s); end
      lat = 0;
      do begin
         @(negedge clk);
         acc_valid_i = 1'b0;
         req_i = (dup && lat == 2);
         lat++;
      end while (!done_o && lat < 40);
      req_i = 1'b0;
      check(victim_o == IW'(exp_vic), {tag, " victim"}, victim_o, exp_vic);
      check(lat == exp_lat, {tag, " latency"}, lat, exp_lat);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o, "R1 busy after reset", busy_o, 0);
      check(!done_o, "R1 done after reset", done_o, 0);

      // R1/R9: FIFO ring order from reset
      for (int i = 0; i < N; i++) ask(i, 1, "R9 ring order");
      // R4: all referenced -> full lap plus one, start slot
      ask(0, N + 1, "R4 all referenced");
      ask(1, 1, "R6 hand moved past victim");

      // R8: duplicate request while busy ignored
      for (int s = 2; s < N; s++) touch(s);
      ask(2, N + 1, "R8 long search", 0, 0, 1);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check(!done_o, "R8 no extra done", done_o, 0);
         check(!busy_o, "R8 idle after done", busy_o, 0);
      end

      // R5: aging
      touch(3); touch(4);
      age();
      ask(3, 1, "R5 aging cleared flags");

      // R2: skips
      touch(4); touch(5);
      ask(6, 3, "R2 skip referenced slots");

      // R7: access colliding with the hand loses
      age();
      touch(7);
      ask(0, 2, "R7 hand beats access", 1, 7);
      for (int s = 1; s < N - 1; s++) touch(s);
      ask(7, N - 1, "R7 collided flag stayed clear");

      // R7: access ahead of the hand during a search
      ask(2, 3, "R7 access ahead of hand", 1, 1);

      // pseudo-random phase against the model
      begin
         logic [15:0] lf = 16'hACE1;
         for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            req_i       = lf[0] & lf[3];
            acc_valid_i = lf[1];
            acc_slot_i  = lf[6:4];
            age_clr_i   = (lf[11:8] == 4'hF);
         end
         @(negedge clk);
         req_i = 1'b0; acc_valid_i = 1'b0; age_clr_i = 1'b0;
         repeat (N + 3) @(negedge clk);
         check(dones_seen > 100, "R3 victims produced in mixed traffic", dones_seen, 101);
      end

      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         checks++;
         failures++;
         $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule